// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps a short list of per-packet transmit completion records. Each time the transmit engine finishes a packet it presents a one-cycle push with its outcome flags; the block turns them into a byte-wide record and stores it. The host sees the oldest unread record on a byte-wide read port. A host write strobe to the same register discards that record and brings the next one forward.

The block also drives two interrupt causes. The first is a completion cause, raised when the visible record carries an error or asks for an interrupt. The second is an adapter-failure cause, raised when a jabber or underrun outcome has locked the transmitter. While locked, the transmit-enable output is held low. A one-cycle transmitter reset pulse clears the lock and empties the list.

If records arrive while every slot is occupied, the new record is lost. The oldest stored record is then marked so that the host knows records went missing.

Top module: `txstat_stack`

## Requirements
- R1: An accepted push stores a record with bit 7 = 1 (complete), bit 6 = push_irq_req, bit 5 = push_jabber, bit 4 = push_underrun, bit 3 = push_maxcoll, and bits 2..0 = 0. The record shows on host_rd_data in the cycle after the push when it is the oldest entry.
- R2: host_rd_data shows the oldest unread record. Records leave in the order they were pushed.
- R3: A host_wr pulse removes the visible record, effective in the next cycle. A host_wr pulse while the list is empty has no effect.
- R4: While the list is empty, host_rd_data reads 0x00, so bit 7 is clear.
- R5: The list holds DEPTH records (default 4). A push that arrives while the list is full and no pop happens in the same cycle is dropped, and bit 2 (overflow) of the visible record is set.
- R6: When a push and a host_wr arrive in the same cycle on a full list, both take effect: the oldest record leaves, the new one is stored, and overflow is not set.
- R7: tx_complete_irq is high exactly when the list is non-empty and the visible record has any of bits 6, 5, 4, 3 or 2 set.
- R8: A push with push_jabber or push_underrun set drives tx_enable low and adapter_fail_irq high from the next cycle, and both stay that way until a tx_reset pulse.
- R9: A tx_reset pulse empties the list and clears the lock. It takes priority over a push or host_wr in the same cycle.
- R10: After rst_n is released, the list is empty, tx_enable is 1, and tx_complete_irq and adapter_fail_irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | One-cycle push of a packet outcome |
| push_irq_req | input | 1 | Packet asked for an interrupt on success |
| push_jabber | input | 1 | Jabber error on the packet |
| push_underrun | input | 1 | Underrun on the packet |
| push_maxcoll | input | 1 | Packet hit the maximum collision count |
| host_wr | input | 1 | Host write to the status register; pops the visible record |
| host_rd_data | output | 8 | Visible record, 0x00 when empty |
| tx_reset | input | 1 | Transmitter reset pulse |
| tx_complete_irq | output | 1 | Completion interrupt cause |
| adapter_fail_irq | output | 1 | Adapter-failure interrupt cause (locked) |
| tx_enable | output | 1 | Transmitter may run |

## Verification
The hardest situation to reach is a full list that receives a push while the host writes in the same cycle. It sits right beside the overflow case, where the push is dropped and the visible record is flagged. Directed steps fill the list to exactly DEPTH entries and then apply both cases back to back. The random phase raises the push rate well above the pop rate, so the list sits at full for long stretches and keeps meeting coincident pops. Reset pulses are also placed during pushes, to cover their priority over a push in the same cycle.

// File: rtl/txstat_pkg.sv
package txstat_pkg;
  typedef logic [7:0] txrec_t;

  localparam int unsigned BIT_DONE = 7;
  localparam int unsigned BIT_IRQ  = 6;
  localparam int unsigned BIT_JAB  = 5;
  localparam int unsigned BIT_UND  = 4;
  localparam int unsigned BIT_MAXC = 3;
  localparam int unsigned BIT_OVF  = 2;

  function automatic txrec_t txs_make(input logic irq, input logic jab,
                                      input logic und, input logic mc);
    txrec_t r;
    r = '0;
    r[BIT_DONE] = 1'b1;
    r[BIT_IRQ]  = irq;
    r[BIT_JAB]  = jab;
    r[BIT_UND]  = und;
    r[BIT_MAXC] = mc;
    return r;
  endfunction

  function automatic logic txs_fatal(input logic jab, input logic und);
    return jab | und;
  endfunction

  function automatic logic txs_wants_irq(input txrec_t r);
    return r[BIT_IRQ] | r[BIT_JAB] | r[BIT_UND] | r[BIT_MAXC] | r[BIT_OVF];
  endfunction
endpackage

// File: rtl/txstat_queue.sv
module txstat_queue
  import txstat_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   clr,
  input  logic   push,
  input  txrec_t push_rec,
  input  logic   pop,
  output txrec_t top,
  output logic   nonempty,
  output logic   full,
  output logic   dropped
);
  txrec_t        ent_q [DEPTH];
  txrec_t        ent_d [DEPTH];
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pop_ok;

  assign nonempty = (cnt_q != '0);
  assign full     = (cnt_q == CW'(DEPTH));
  assign pop_ok   = pop && nonempty;
  assign dropped  = push && full && !pop_ok && !clr;
  assign top      = nonempty ? ent_q[0] : '0;

  always_comb begin
    ent_d = ent_q;
    cnt_d = cnt_q;
    if (pop_ok) begin
      for (int i = 0; i < DEPTH - 1; i++) ent_d[i] = ent_q[i+1];
      ent_d[DEPTH-1] = '0;
      cnt_d = cnt_q - 1'b1;
    end
    if (push) begin
      if (cnt_d < CW'(DEPTH)) begin
        for (int i = 0; i < DEPTH; i++)
          if (CW'(i) == cnt_d) ent_d[i] = push_rec;
        cnt_d = cnt_d + 1'b1;
      end else begin
        ent_d[0][BIT_OVF] = 1'b1;
      end
    end
    if (clr) begin
      for (int i = 0; i < DEPTH; i++) ent_d[i] = '0;
      cnt_d = '0;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ent_q[g] <= '0;
        else        ent_q[g] <= ent_d[g];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/txstat_lock.sv
module txstat_lock
  import txstat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic push,
  input  logic jab,
  input  logic und,
  output logic locked
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        locked <= 1'b0;
    else if (clr)                      locked <= 1'b0;
    else if (push && txs_fatal(jab, und)) locked <= 1'b1;
  end
endmodule

// File: rtl/txstat_stack.sv
module txstat_stack
  import txstat_pkg::*;
#(
  parameter int unsigned DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       push_valid,
  input  logic       push_irq_req,
  input  logic       push_jabber,
  input  logic       push_underrun,
  input  logic       push_maxcoll,
  input  logic       host_wr,
  output logic [7:0] host_rd_data,
  input  logic       tx_reset,
  output logic       tx_complete_irq,
  output logic       adapter_fail_irq,
  output logic       tx_enable
);
  txrec_t new_rec;
  txrec_t top_rec;
  logic   stk_nonempty;
  logic   stk_full;
  logic   push_drop;
  logic   tx_locked;

  assign new_rec = txs_make(push_irq_req, push_jabber, push_underrun, push_maxcoll);

  txstat_queue #(.DEPTH(DEPTH)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tx_reset),
    .push     (push_valid),
    .push_rec (new_rec),
    .pop      (host_wr),
    .top      (top_rec),
    .nonempty (stk_nonempty),
    .full     (stk_full),
    .dropped  (push_drop)
  );

  txstat_lock u_lock (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (tx_reset),
    .push   (push_valid),
    .jab    (push_jabber),
    .und    (push_underrun),
    .locked (tx_locked)
  );

  assign host_rd_data     = top_rec;
  assign tx_complete_irq  = stk_nonempty && txs_wants_irq(top_rec);
  assign adapter_fail_irq = tx_locked;
  assign tx_enable        = !tx_locked;
endmodule

// File: rtl/txstat_stack_chk.sv
module txstat_stack_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       push_valid,
  input logic       push_jabber,
  input logic       push_underrun,
  input logic       host_wr,
  input logic       tx_reset,
  input logic [7:0] host_rd_data,
  input logic       tx_complete_irq,
  input logic       adapter_fail_irq,
  input logic       tx_enable,
  input logic       push_drop
);
  // R9
  reset_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_reset |=> (host_rd_data == 8'h00 && tx_enable));
  // R8
  fatal_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_valid && (push_jabber || push_underrun) && !tx_reset) |=> !tx_enable);
  // R8
  lock_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_enable |-> adapter_fail_irq);
  // R5
  drop_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> host_rd_data[2]);
  // R4
  top_complete_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd_data != 8'h00) |-> host_rd_data[7]);
  // R2
  idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_reset && !push_valid && !host_wr) |=> $stable(host_rd_data));
  // R7
  irq_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_complete_irq |-> host_rd_data[7]);
endmodule

bind txstat_stack txstat_stack_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .push_valid       (push_valid),
  .push_jabber      (push_jabber),
  .push_underrun    (push_underrun),
  .host_wr          (host_wr),
  .tx_reset         (tx_reset),
  .host_rd_data     (host_rd_data),
  .tx_complete_irq  (tx_complete_irq),
  .adapter_fail_irq (adapter_fail_irq),
  .tx_enable        (tx_enable),
  .push_drop        (push_drop)
);

// File: tb/txstat_stack_bench.sv
module txstat_stack_bench;
  localparam int D = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       push_valid = 0, push_irq_req = 0, push_jabber = 0;
  logic       push_underrun = 0, push_maxcoll = 0, host_wr = 0, tx_reset = 0;
  logic [7:0] host_rd_data;
  logic       tx_complete_irq, adapter_fail_irq, tx_enable;

  int n_chk = 0, n_bad = 0;
  logic [7:0] mq [D];
  int mcnt = 0;
  logic mlock = 0;

  always #4 clk = ~clk;

  txstat_stack #(.DEPTH(D)) u_txstat_stack (
    .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_irq_req(push_irq_req),
    .push_jabber(push_jabber), .push_underrun(push_underrun), .push_maxcoll(push_maxcoll),
    .host_wr(host_wr), .host_rd_data(host_rd_data), .tx_reset(tx_reset),
    .tx_complete_irq(tx_complete_irq), .adapter_fail_irq(adapter_fail_irq),
    .tx_enable(tx_enable));

  function automatic logic [7:0] exp_rec(logic i, logic j, logic u, logic m);
    return {1'b1, i, j, u, m, 3'b000};
  endfunction

  function automatic logic [7:0] exp_top();
    return (mcnt > 0) ? mq[0] : 8'h00;
  endfunction

  function automatic logic exp_irq();
    return (mcnt > 0) && (mq[0][6:2] != 5'b0);
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " rd"}, host_rd_data, exp_top());
    chk("R7 irq", {7'b0, tx_complete_irq}, {7'b0, exp_irq()});
    chk("R8 en", {7'b0, tx_enable}, {7'b0, !mlock});
    chk("R8 fail", {7'b0, adapter_fail_irq}, {7'b0, mlock});
  endtask

  task automatic model();
    if (tx_reset) begin
      mcnt = 0; mlock = 0;
      for (int i = 0; i < D; i++) mq[i] = 8'h00;
    end else begin
      if (push_valid && (push_jabber || push_underrun)) mlock = 1;
      if (host_wr && mcnt > 0) begin
        for (int i = 0; i < D - 1; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      if (push_valid) begin
        if (mcnt < D) begin
          mq[mcnt] = exp_rec(push_irq_req, push_jabber, push_underrun, push_maxcoll);
          mcnt++;
        end else mq[0][2] = 1'b1;
      end
    end
  endtask

  task automatic step(string tag, logic p, logic i, logic j, logic u, logic m,
                      logic w, logic r);
    push_valid = p; push_irq_req = i; push_jabber = j; push_underrun = u;
    push_maxcoll = m; host_wr = w; tx_reset = r;
    @(posedge clk);
    model();
    @(negedge clk);
    push_valid = 0; host_wr = 0; tx_reset = 0;
    chk_all(tag);
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < D; i++) mq[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R10 reset");
    chk("R4 empty", host_rd_data, 8'h00);
    step("R3 pop-empty", 0, 0, 0, 0, 0, 1, 0);
    // R1 encoding: all flags except fatal
    step("R1 rec", 1, 1, 0, 0, 1, 0, 0);
    chk("R1 enc", host_rd_data, 8'hC8);
    step("R3 pop", 0, 0, 0, 0, 0, 1, 0);
    chk("R4 empty-after", host_rd_data, 8'h00);
    // R2 order, R5 overflow
    step("R2 fill", 1, 0, 0, 0, 0, 0, 0);
    step("R2 fill", 1, 1, 0, 0, 0, 0, 0);
    step("R2 fill", 1, 0, 0, 0, 1, 0, 0);
    step("R2 fill", 1, 1, 0, 0, 1, 0, 0);
    chk("R2 oldest", host_rd_data, 8'h80);
    step("R5 drop", 1, 1, 0, 0, 1, 0, 0);
    chk("R5 ovf", host_rd_data, 8'h84);
    // R6 push+pop on full
    step("R6 both", 1, 0, 0, 0, 0, 1, 0);
    chk("R6 next", host_rd_data, 8'hC0);
    step("R2 pop", 0, 0, 0, 0, 0, 1, 0);
    chk("R2 third", host_rd_data, 8'h88);
    // R8 lock via underrun, then jabber
    step("R8 und", 1, 0, 0, 1, 0, 0, 0);
    chk("R8 enable-low", {7'b0, tx_enable}, 8'h00);
    step("R8 hold", 0, 0, 0, 0, 0, 1, 0);
    // R9 reset with push same cycle
    step("R9 rst", 1, 0, 1, 0, 0, 0, 1);
    chk("R9 empty", host_rd_data, 8'h00);
    step("R8 jab", 1, 0, 1, 0, 0, 0, 0);
    step("R9 rst2", 0, 0, 0, 0, 0, 0, 1);
    // random phase
    void'($urandom(32'h5eed_0042));
    for (int k = 0; k < 4000; k++) begin
      automatic int rp = $urandom_range(0, 99);
      automatic int rw = $urandom_range(0, 99);
      automatic int rr = $urandom_range(0, 199);
      step("R2 rnd", rp < 55, $urandom_range(0, 1), $urandom_range(0, 15) == 0,
           $urandom_range(0, 15) == 0, $urandom_range(0, 3) == 0, rw < 35, rr == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule